// File: doc/BRIEF.md
# Bitfield Move Unit

This unit executes the family of bitfield-move operations found in a 64-bit integer instruction set. From one instruction word it decodes the operand width, the move kind and two 6-bit immediates: a rotate amount and the index of the field's top bit. With these it extracts a field and sign- or zero-extends it, deposits a low-order field at an offset, or inserts a field into an existing destination value. Byte, halfword and word sign extension and arithmetic right shift by a constant are ordinary settings of the same two immediates. They are not separate paths.

The datapath rotates the source right once. It then builds a write mask and a top mask and merges the rotated source over a background. That background is either zero or the old destination value. Bits above the field are filled with copies of the field's top bit or with the background. A 64-bit lane and a 32-bit lane are built from one parameterised module, and the width bit in the instruction picks between them. Encodings that cannot be executed raise an undefined flag and give a zero result. The result is registered, and it appears one cycle after the input strobe.

Top module: `bitfield_mover`

## Requirements
- R1: The instruction word is decoded with these fixed positions: width bit at 31, move kind at 30:29, fixed opcode pattern `100110` at 28:23, mode bit at 22, rotate amount at 21:16 and top-bit index at 15:10. Bits 9:0 have no effect on the result.
- R2: `undef` is set, and `result` is all zeros, in each of these cases:
  - the move kind is `11`;
  - bits 28:23 are not `100110`;
  - the width bit is 1 and the mode bit is 0;
  - the width bit is 0 and any of the mode bit, bit 5 of the rotate amount or bit 5 of the top-bit index is 1.
- R3: `out_valid` equals `in_valid` delayed by one clock. `result` and `undef` are captured only on cycles with `in_valid` high, and otherwise they hold their values.
- R4: While synchronous reset is high, `out_valid`, `result` and `undef` are zero from the first clock edge onwards.
- R5: For kind `00` (signed) with index ≥ rotate, the result is source bits [index:rotate] placed at bit 0, with every higher bit a copy of source bit `index`.
- R6: For kind `00` with index < rotate, source bits [index:0] are placed starting at bit (datasize − rotate). The bits below are zero, and the bits above copy source bit `index`.
- R7: For kind `10` (unsigned), the field is selected and placed as in R5 and R6, and every bit outside the field is zero.
- R8: For kind `01` (insert), the field is selected and placed as in R5 and R6. Every bit outside the field keeps the value of `dest_in`.
- R9: With the width bit at 0, only bits 31:0 of the operands take part, and result bits 63:32 are zero.
- R10: Rotate 0 with index 7, 15 or 31 under kind `00` gives byte, halfword or word sign extension. Index 63 (64-bit) or 31 (32-bit) gives an arithmetic right shift by the rotate amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and instruction are valid this cycle |
| instr | input | 32 | Instruction word |
| src_in | input | 64 | Source operand |
| dest_in | input | 64 | Current destination value (background for insert) |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 64 | Bitfield-move result |
| undef | output | 1 | Encoding was not executable |

## Verification
The merge is purely combinational and ends in one register stage. As a result, `result`, `undef` and `out_valid` for a strobe accepted at clock edge k are all due after edge k and stay stable until edge k+1. The bench applies each operation at a falling edge and holds `in_valid` for exactly one rising edge. It samples at the next falling edge, which lies half a period after the capture edge and half a period before the next one. Idle-cycle checks sample at later falling edges to confirm the held values. Reset checks sample after two rising edges with reset held.

// File: rtl/bfmv_pkg.sv
package bfmv_pkg;

    localparam int XLEN     = 64;
    localparam int HLEN     = 32;
    localparam int IWIDTH   = 32;
    localparam int IMMW     = $clog2(XLEN);
    localparam int NUM_LANE = 2;

    localparam logic [5:0] FIXED_OPCODE = 6'b100110;

    typedef enum logic [1:0] {
        MV_SIGNED   = 2'b00,
        MV_INSERT   = 2'b01,
        MV_UNSIGNED = 2'b10,
        MV_RSVD     = 2'b11
    } mv_kind_e;

    // Instruction word view, most significant field first.
    typedef struct packed {
        logic            wide;
        mv_kind_e        kind;
        logic [5:0]      fixed;
        logic            mode;
        logic [IMMW-1:0] rot;
        logic [IMMW-1:0] top_idx;
        logic [9:0]      regs;
    } instr_fields_t;

    typedef struct packed {
        logic            wide;
        logic            zero_bg;
        logic            sign_top;
        logic            illegal;
        logic [IMMW-1:0] rot;
        logic [IMMW-1:0] top_idx;
    } mv_ctrl_t;

    // Lane width for a given lane index: lane 0 full width, lane 1 half.
    function automatic int lane_width(input int g);
        return (g == 0) ? XLEN : HLEN;
    endfunction

endpackage

// File: rtl/bfmv_decode.sv
module bfmv_decode
    import bfmv_pkg::*;
(
    input  logic [IWIDTH-1:0] instr,
    output mv_ctrl_t          ctrl
);

    instr_fields_t f;
    logic bad_fixed;
    logic bad_kind;
    logic bad_width;

    assign f = instr_fields_t'(instr);

    always_comb begin
        bad_fixed = (f.fixed != FIXED_OPCODE);
        bad_kind  = (f.kind == MV_RSVD);
        if (f.wide) begin
            bad_width = !f.mode;
        end else begin
            bad_width = f.mode | f.rot[IMMW-1] | f.top_idx[IMMW-1];
        end
    end

    always_comb begin
        ctrl.wide     = f.wide;
        ctrl.zero_bg  = (f.kind != MV_INSERT);
        ctrl.sign_top = (f.kind == MV_SIGNED);
        ctrl.illegal  = bad_fixed | bad_kind | bad_width;
        ctrl.rot      = f.rot;
        ctrl.top_idx  = f.top_idx;
    end

endmodule

// File: rtl/bfmv_mask_gen.sv
module bfmv_mask_gen #(
    parameter int W = 64
) (
    input  logic [$clog2(W)-1:0] rot,
    input  logic [$clog2(W)-1:0] top_idx,
    output logic [W-1:0]         wmask,
    output logic [W-1:0]         tmask
);

    localparam int AW = $clog2(W);
    localparam logic [W-1:0] SEED = {{(W-1){1'b1}}, 1'b0};

    logic [W-1:0]   welem;
    logic [2*W-1:0] wdouble;
    logic [AW-1:0]  span;

    // Ones(top_idx+1): shifting the seed by k leaves bits 0..k clear.
    assign welem   = ~(SEED << top_idx);
    assign wdouble = {welem, welem} >> rot;
    assign wmask   = wdouble[W-1:0];

    // Field span modulo the lane width; AW-bit arithmetic wraps naturally.
    assign span  = top_idx - rot;
    assign tmask = ~(SEED << span);

endmodule

// File: rtl/bfmv_lane.sv
module bfmv_lane #(
    parameter int W = 64
) (
    input  logic [$clog2(W)-1:0] rot,
    input  logic [$clog2(W)-1:0] top_idx,
    input  logic                 zero_bg,
    input  logic                 sign_top,
    input  logic [W-1:0]         src,
    input  logic [W-1:0]         dst,
    output logic [W-1:0]         res
);

    logic [W-1:0]   wmask;
    logic [W-1:0]   tmask;
    logic [2*W-1:0] rdouble;
    logic [W-1:0]   rotated;
    logic [W-1:0]   bg;
    logic [W-1:0]   bot;
    logic [W-1:0]   top;

    bfmv_mask_gen #(.W(W)) i_masks (
        .rot     (rot),
        .top_idx (top_idx),
        .wmask   (wmask),
        .tmask   (tmask)
    );

    assign rdouble = {src, src} >> rot;
    assign rotated = rdouble[W-1:0];

    always_comb begin
        bg  = zero_bg ? '0 : dst;
        bot = (bg & ~wmask) | (rotated & wmask);
        top = sign_top ? {W{src[top_idx]}} : bg;
        res = (top & ~tmask) | (bot & tmask);
    end

endmodule

// File: rtl/bitfield_mover.sv
module bitfield_mover
    import bfmv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [IWIDTH-1:0] instr,
    input  logic [XLEN-1:0]   src_in,
    input  logic [XLEN-1:0]   dest_in,
    output logic              out_valid,
    output logic [XLEN-1:0]   result,
    output logic              undef
);

    mv_ctrl_t        ctrl;
    logic [XLEN-1:0] lane_res [NUM_LANE];
    logic [XLEN-1:0] next_result;

    bfmv_decode i_decode (
        .instr (instr),
        .ctrl  (ctrl)
    );

    for (genvar g = 0; g < NUM_LANE; g++) begin : g_lane
        localparam int W  = lane_width(g);
        localparam int AW = $clog2(W);
        logic [W-1:0] res_w;

        bfmv_lane #(.W(W)) i_lane (
            .rot      (ctrl.rot[AW-1:0]),
            .top_idx  (ctrl.top_idx[AW-1:0]),
            .zero_bg  (ctrl.zero_bg),
            .sign_top (ctrl.sign_top),
            .src      (src_in[W-1:0]),
            .dst      (dest_in[W-1:0]),
            .res      (res_w)
        );

        assign lane_res[g] = XLEN'(res_w);
    end

    always_comb begin
        if (ctrl.illegal) begin
            next_result = '0;
        end else if (ctrl.wide) begin
            next_result = lane_res[0];
        end else begin
            next_result = lane_res[1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            undef     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= next_result;
                undef  <= ctrl.illegal;
            end
        end
    end

endmodule

// File: rtl/bfmv_checker.sv
module bfmv_checker
    import bfmv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [IWIDTH-1:0] instr,
    input logic [XLEN-1:0]   src_in,
    input logic [XLEN-1:0]   dest_in,
    input logic              out_valid,
    input logic [XLEN-1:0]   result,
    input logic              undef
);

    localparam logic [21:0] IDENT64 = {1'b1, 2'b00, FIXED_OPCODE, 1'b1, 6'd0, 6'd63};

    assert_follow_R3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result) && $stable(undef)));

    assert_undef_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && undef) |-> (result == '0));

    assert_rsvd_kind_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[30:29] == 2'b11) |=> undef);

    assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !instr[31]) |=> (result[63:32] == 32'd0));

    assert_identity_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[31:10] == IDENT64) |=> (result == $past(src_in) && !undef));

    assert_dest_kept_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[31:10] == {1'b1, 2'b01, FIXED_OPCODE, 1'b1, 6'd0, 6'd0})
        |=> (result[63:1] == $past(dest_in[63:1])));

endmodule

bind bitfield_mover bfmv_checker i_checker (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .instr     (instr),
    .src_in    (src_in),
    .dest_in   (dest_in),
    .out_valid (out_valid),
    .result    (result),
    .undef     (undef)
);

// File: tb/test_bitfield_mover.sv
module test_bitfield_mover;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] instr;
    logic [63:0] src_in;
    logic [63:0] dest_in;
    logic        out_valid;
    logic [63:0] result;
    logic        undef;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    bitfield_mover i_bitfield_mover (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .instr     (instr),
        .src_in    (src_in),
        .dest_in   (dest_in),
        .out_valid (out_valid),
        .result    (result),
        .undef     (undef)
    );

    function automatic logic [63:0] ones_n(input int w);
        if (w >= 64) return '1;
        return (64'd1 << w) - 64'd1;
    endfunction

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    function automatic logic [31:0] enc(input bit sf, input bit [1:0] kind, input bit n,
                                        input bit [5:0] r, input bit [5:0] s, input bit [9:0] regs);
        return {sf, kind, 6'b100110, n, r, s, regs};
    endfunction

    // Shift-based model written from the field placement rules.
    function automatic logic [63:0] model(input bit sf, input bit [1:0] kind, input int r,
                                          input int s, input logic [63:0] a, input logic [63:0] d);
        int ds;
        int w;
        int pos;
        logic [63:0] dm;
        logic [63:0] field;
        logic [63:0] fmask;
        logic [63:0] res;
        bit tb;
        ds = sf ? 64 : 32;
        dm = ones_n(ds);
        a  = a & dm;
        d  = d & dm;
        if (s >= r) begin
            w = s - r + 1;
            pos = 0;
            field = (a >> r) & ones_n(w);
        end else begin
            w = s + 1;
            pos = ds - r;
            field = a & ones_n(w);
        end
        tb = field[w-1];
        fmask = ones_n(w) << pos;
        case (kind)
            2'b00:   res = (field << pos) | (tb ? (dm & ~ones_n(pos + w)) : 64'd0);
            2'b10:   res = field << pos;
            default: res = (d & ~fmask) | (field << pos);
        endcase
        return res & dm;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Starts at a falling edge, one rising edge captures, returns at the next falling edge.
    task automatic apply(input logic [31:0] i, input logic [63:0] a, input logic [63:0] d);
        in_valid = 1'b1;
        instr    = i;
        src_in   = a;
        dest_in  = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        in_valid = 1'b1;
        instr = enc(1, 2'b00, 1, 6'd0, 6'd63, 10'd0);
        src_in = 64'hDEAD_BEEF_0123_4567;
        repeat (2) @(negedge clk);
        check("R4 out_valid in reset", 64'(out_valid), 64'd0);
        check("R4 result in reset", result, 64'd0);
        check("R4 undef in reset", 64'(undef), 64'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_sweep(input bit sf);
        int ds;
        ds = sf ? 64 : 32;
        for (int k = 0; k < 3; k++) begin
            bit [1:0] kind;
            kind = (k == 0) ? 2'b00 : ((k == 1) ? 2'b10 : 2'b01);
            for (int r = 0; r < ds; r++) begin
                for (int s = 0; s < ds; s++) begin
                    logic [63:0] a;
                    logic [63:0] d;
                    string tag;
                    a = rnd64();
                    d = rnd64();
                    if (kind == 2'b01)      tag = "R8";
                    else if (kind == 2'b10) tag = "R7";
                    else if (s >= r)        tag = "R5";
                    else                    tag = "R6";
                    if (!sf) tag = {tag, " R9"};
                    apply(enc(sf, kind, sf, 6'(r), 6'(s), 10'($urandom())), a, d);
                    check($sformatf("%s kind=%0d r=%0d s=%0d", tag, kind, r, s),
                          result, model(sf, kind, r, s, a, d));
                    if (undef !== 1'b0 || out_valid !== 1'b1)
                        check($sformatf("%s flags r=%0d s=%0d", tag, r, s),
                              {62'd0, undef, out_valid}, 64'd1);
                end
            end
        end
    endtask

    task automatic t_special();
        logic [63:0] a;
        a = 64'h1234_5678_9ABC_DE80;
        apply(enc(1, 2'b00, 1, 6'd0, 6'd7, 10'd0), a, rnd64());
        check("R10 byte sign extend", result, 64'hFFFF_FFFF_FFFF_FF80);
        a = 64'h0000_0000_0000_7F81;
        apply(enc(1, 2'b00, 1, 6'd0, 6'd15, 10'd0), a, rnd64());
        check("R10 half sign extend positive", result, 64'h0000_0000_0000_7F81);
        a = 64'h5555_5555_8000_0001;
        apply(enc(1, 2'b00, 1, 6'd0, 6'd31, 10'd0), a, rnd64());
        check("R10 word sign extend", result, 64'hFFFF_FFFF_8000_0001);
        for (int k = 0; k < 64; k++) begin
            a = rnd64();
            apply(enc(1, 2'b00, 1, 6'(k), 6'd63, 10'd0), a, rnd64());
            check($sformatf("R10 asr64 by %0d", k), result, 64'($signed(a) >>> k));
        end
        for (int k = 0; k < 32; k++) begin
            a = rnd64();
            apply(enc(0, 2'b00, 0, 6'(k), 6'd31, 10'd0), a, rnd64());
            check($sformatf("R10 asr32 by %0d", k), result,
                  {32'd0, 32'($signed(a[31:0]) >>> k)});
        end
    endtask

    task automatic undef_case(input string what, input logic [31:0] i);
        apply(enc(1, 2'b00, 1, 6'd0, 6'd63, 10'd0), 64'hFFFF_0000_FFFF_0000, 64'd0);
        apply(i, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        check({"R2 undef flag ", what}, 64'(undef), 64'd1);
        check({"R2 zero result ", what}, result, 64'd0);
    endtask

    task automatic t_undef();
        logic [31:0] base;
        undef_case("kind 11 wide", enc(1, 2'b11, 1, 6'd3, 6'd9, 10'd0));
        undef_case("kind 11 narrow", enc(0, 2'b11, 0, 6'd3, 6'd9, 10'd0));
        undef_case("wide mode 0", enc(1, 2'b00, 0, 6'd3, 6'd9, 10'd0));
        undef_case("narrow mode 1", enc(0, 2'b10, 1, 6'd3, 6'd9, 10'd0));
        undef_case("narrow rot bit5", enc(0, 2'b01, 0, 6'd35, 6'd9, 10'd0));
        undef_case("narrow idx bit5", enc(0, 2'b00, 0, 6'd3, 6'd41, 10'd0));
        base = enc(1, 2'b00, 1, 6'd3, 6'd9, 10'd0);
        for (int b = 23; b <= 28; b++) begin
            logic [31:0] bad;
            bad = base;
            bad[b] = ~bad[b];
            undef_case($sformatf("fixed bit %0d", b), bad);
        end
    endtask

    task automatic t_timing();
        logic [63:0] a;
        logic [63:0] held;
        a = rnd64();
        apply(enc(1, 2'b10, 1, 6'd8, 6'd23, 10'd0), a, 64'd0);
        check("R3 out_valid one cycle after strobe", 64'(out_valid), 64'd1);
        check("R3 captured result", result, model(1, 2'b10, 8, 23, a, 64'd0));
        held = result;
        for (int c = 0; c < 3; c++) begin
            instr = enc(1, 2'b11, 0, 6'($urandom()), 6'($urandom()), 10'd0);
            src_in = rnd64();
            dest_in = rnd64();
            @(negedge clk);
            check("R3 out_valid low when idle", 64'(out_valid), 64'd0);
            check("R3 result held when idle", result, held);
            check("R3 undef held when idle", 64'(undef), 64'd0);
        end
    endtask

    task automatic t_fields();
        logic [63:0] a;
        logic [63:0] d;
        logic [63:0] exp;
        a = rnd64();
        d = rnd64();
        exp = model(1, 2'b01, 12, 40, a, d);
        for (int k = 0; k < 4; k++) begin
            logic [9:0] regs;
            regs = (k == 0) ? 10'h000 : ((k == 1) ? 10'h3FF : 10'($urandom()));
            apply(enc(1, 2'b01, 1, 6'd12, 6'd40, regs), a, d);
            check($sformatf("R1 low bits %h ignored", regs), result, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        instr = '0;
        src_in = '0;
        dest_in = '0;
        @(negedge clk);
        t_reset();
        t_fields();
        t_timing();
        t_special();
        t_undef();
        t_sweep(1'b1);
        t_sweep(1'b0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule